// File: doc/BRIEF.md
# Two-Channel Packet DMA Control Register Block

This block holds the per-channel control and status registers for a two-channel ATA packet DMA engine and sits on a simple memory-mapped read/write bus. Each channel has a control word, a status byte, a descriptor count, a next-descriptor pointer and two FIFO threshold values. The block drives the engine with a one-cycle start strobe, a held engine reset and an interrupt line that can be masked.

A global lock byte must hold the unlock value before any start request takes effect. A control write that does not start the engine leaves the channel in register mode, so taskfile accesses bypass the packet engine. Completion and error causes from the engine are latched into the status byte. A read of the status byte returns those causes and clears them.

Top module: `dmactl_regs`

## Requirements
- R1: Channel c registers sit at byte address 0x80 + 0x20*c plus offset: control 0x00 (16 bits), status 0x02 (8 bits), descriptor count 0x04 (16 bits), next-descriptor pointer 0x0C (32 bits), input threshold 0x14 and output threshold 0x16 (16 bits each). The lock byte is at 0xC7. Writes keep only the register's width. Reads of any other address return 0.
- R2: After reset every register reads 0, `go_pulse`, `eng_rst` and `irq` are low, and `reg_mode` is high on both channels.
- R3: A control write with bit 7 set and bit 5 clear, while the lock byte equals 7, raises `go_pulse` for that channel for exactly one cycle, starting in the cycle after the write. Bit 7 always reads back as 0.
- R4: A start request made while the lock byte differs from 7 has no effect: no pulse, and `reg_mode` stays high.
- R5: `eng_rst` follows the stored control bit 5. A write that sets bit 5 clears the status byte and suppresses any start in the same write. While bit 5 is held, engine events are dropped.
- R6: A control write that starts the engine drives `reg_mode` low. Any other control write drives it high.
- R7: Engine events set sticky status bits: done sets bit 6, unexpected device interrupt sets bit 4, and bus error sets bit 0.
- R8: A status read returns the latched bits and clears them. An event arriving in the cycle of the read is kept for the next read.
- R9: `irq` is high when the status byte is nonzero and control bit 8 (mask) is clear.
- R10: Read data and `bus_rvalid` appear in the cycle after `bus_rd`.
- R11: Each channel's state changes only through its own address window and its own event inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data, LSB-aligned |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| evt_done | input | 2 | Per-channel packet-done event |
| evt_uirq | input | 2 | Per-channel unexpected device interrupt |
| evt_perr | input | 2 | Per-channel bus/parity error |
| go_pulse | output | 2 | One-cycle engine start |
| eng_rst | output | 2 | Engine reset, held |
| irq | output | 2 | Per-channel interrupt |
| reg_mode | output | 2 | Channel in register (PIO) mode |
| cpb_count | output | 32 | Descriptor count, 16 bits per channel |
| next_cpb | output | 64 | Next-descriptor pointer, 32 bits per channel |
| fifo_in_thr | output | 32 | Input FIFO threshold per channel |
| fifo_out_thr | output | 32 | Output FIFO threshold per channel |

## Verification
The properties assume a strobe lasts a whole clock period with a stable address, and that event inputs are level samples taken at each rising edge. The stimulus changes every input on the falling edge and keeps it for a whole period. It raises events for a single cycle at a time, and each event it raises, including the one in the cycle of a status read, is one the requirements define. No bus handshake is modelled, because the block accepts every access in the cycle it is presented.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
  // channel-relative offsets
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h02;
  localparam int OFF_CNT  = 'h04;
  localparam int OFF_PTR  = 'h0C;
  localparam int OFF_FIN  = 'h14;
  localparam int OFF_FOUT = 'h16;

  // control bit positions
  localparam int CB_MASK = 8;
  localparam int CB_GO   = 7;
  localparam int CB_RST  = 5;

  // status bit positions
  localparam int SB_DONE = 6;
  localparam int SB_UIRQ = 4;
  localparam int SB_PERR = 0;

  localparam int CTRL_W = 16;
  localparam int STAT_W = 8;
  localparam int HALF_W = 16;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_CNT, SEL_PTR, SEL_FIN, SEL_FOUT
  } reg_sel_e;
endpackage

// File: rtl/dmactl_decode.sv
module dmactl_decode
  import dmactl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE   = 'h80,
  parameter int STRIDE = 'h20,
  parameter int CH     = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int LO = BASE + CH * STRIDE;
  localparam int HI = LO + STRIDE;

  logic              hit;
  logic [ADDR_W-1:0] off;

  assign hit = (int'(addr) >= LO) && (int'(addr) < HI);
  assign off = addr - ADDR_W'(LO);

  always_comb begin
    sel = SEL_NONE;
    if (hit) begin
      case (int'(off))
        OFF_CTRL: sel = SEL_CTRL;
        OFF_STAT: sel = SEL_STAT;
        OFF_CNT:  sel = SEL_CNT;
        OFF_PTR:  sel = SEL_PTR;
        OFF_FIN:  sel = SEL_FIN;
        OFF_FOUT: sel = SEL_FOUT;
        default:  sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dmactl_chan.sv
module dmactl_chan
  import dmactl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              unlocked,
  input  logic              ev_done,
  input  logic              ev_uirq,
  input  logic              ev_perr,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [STAT_W-1:0] stat_q,
  output logic [HALF_W-1:0] cnt_q,
  output logic [DATA_W-1:0] ptr_q,
  output logic [HALF_W-1:0] fin_q,
  output logic [HALF_W-1:0] fout_q,
  output logic              go,
  output logic              eng_rst,
  output logic              irq,
  output logic              reg_mode
);
  logic              wr_ctrl;
  logic              start;
  logic              rst_now;
  logic [STAT_W-1:0] ev_vec;
  logic [CTRL_W-1:0] ctrl_wr;

  assign wr_ctrl = wr_en && (sel == SEL_CTRL);
  assign start   = wr_ctrl && wdata[CB_GO] && !wdata[CB_RST] && unlocked;
  assign rst_now = ctrl_q[CB_RST] || (wr_ctrl && wdata[CB_RST]);

  always_comb begin
    ctrl_wr        = wdata[CTRL_W-1:0];
    ctrl_wr[CB_GO] = 1'b0;
    ev_vec          = '0;
    ev_vec[SB_DONE] = ev_done;
    ev_vec[SB_UIRQ] = ev_uirq;
    ev_vec[SB_PERR] = ev_perr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      stat_q   <= '0;
      cnt_q    <= '0;
      ptr_q    <= '0;
      fin_q    <= '0;
      fout_q   <= '0;
      go       <= 1'b0;
      reg_mode <= 1'b1;
    end else begin
      go <= start;
      if (wr_ctrl) begin
        ctrl_q   <= ctrl_wr;
        reg_mode <= !start;
      end
      if (wr_en && sel == SEL_CNT)  cnt_q  <= wdata[HALF_W-1:0];
      if (wr_en && sel == SEL_PTR)  ptr_q  <= wdata;
      if (wr_en && sel == SEL_FIN)  fin_q  <= wdata[HALF_W-1:0];
      if (wr_en && sel == SEL_FOUT) fout_q <= wdata[HALF_W-1:0];
      if (rst_now)
        stat_q <= '0;
      else
        stat_q <= ((rd_en && sel == SEL_STAT) ? '0 : stat_q) | ev_vec;
    end
  end

  assign eng_rst = ctrl_q[CB_RST];
  assign irq     = (|stat_q) && !ctrl_q[CB_MASK];
endmodule

// File: rtl/dmactl_regs.sv
module dmactl_regs
  import dmactl_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CHAN_BASE   = 'h80,
  parameter int CHAN_STRIDE = 'h20,
  parameter int LOCK_ADDR   = 'hC7,
  parameter int UNLOCK_VAL  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_rvalid,
  input  logic [NUM_CH-1:0]        evt_done,
  input  logic [NUM_CH-1:0]        evt_uirq,
  input  logic [NUM_CH-1:0]        evt_perr,
  output logic [NUM_CH-1:0]        go_pulse,
  output logic [NUM_CH-1:0]        eng_rst,
  output logic [NUM_CH-1:0]        irq,
  output logic [NUM_CH-1:0]        reg_mode,
  output logic [NUM_CH*16-1:0]     cpb_count,
  output logic [NUM_CH*DATA_W-1:0] next_cpb,
  output logic [NUM_CH*16-1:0]     fifo_in_thr,
  output logic [NUM_CH*16-1:0]     fifo_out_thr
);
  localparam int LOCK_W = 8;

  reg_sel_e          sel    [NUM_CH];
  logic [CTRL_W-1:0] ctrl_q [NUM_CH];
  logic [STAT_W-1:0] stat_q [NUM_CH];
  logic [HALF_W-1:0] cnt_q  [NUM_CH];
  logic [DATA_W-1:0] ptr_q  [NUM_CH];
  logic [HALF_W-1:0] fin_q  [NUM_CH];
  logic [HALF_W-1:0] fout_q [NUM_CH];
  logic [LOCK_W-1:0] lock_q;
  logic              unlocked;
  logic [DATA_W-1:0] rd_nxt;

  assign unlocked = (lock_q == LOCK_W'(UNLOCK_VAL));

  always_ff @(posedge clk) begin
    if (!rst_n)
      lock_q <= '0;
    else if (bus_wr && bus_addr == ADDR_W'(LOCK_ADDR))
      lock_q <= bus_wdata[LOCK_W-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dmactl_decode #(
      .ADDR_W(ADDR_W), .BASE(CHAN_BASE), .STRIDE(CHAN_STRIDE), .CH(c)
    ) u_dec (
      .addr(bus_addr),
      .sel (sel[c])
    );

    dmactl_chan #(.DATA_W(DATA_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .rd_en   (bus_rd),
      .sel     (sel[c]),
      .wdata   (bus_wdata),
      .unlocked(unlocked),
      .ev_done (evt_done[c]),
      .ev_uirq (evt_uirq[c]),
      .ev_perr (evt_perr[c]),
      .ctrl_q  (ctrl_q[c]),
      .stat_q  (stat_q[c]),
      .cnt_q   (cnt_q[c]),
      .ptr_q   (ptr_q[c]),
      .fin_q   (fin_q[c]),
      .fout_q  (fout_q[c]),
      .go      (go_pulse[c]),
      .eng_rst (eng_rst[c]),
      .irq     (irq[c]),
      .reg_mode(reg_mode[c])
    );

    assign cpb_count   [c*16 +: 16]        = cnt_q[c];
    assign next_cpb    [c*DATA_W +: DATA_W] = ptr_q[c];
    assign fifo_in_thr [c*16 +: 16]        = fin_q[c];
    assign fifo_out_thr[c*16 +: 16]        = fout_q[c];
  end

  always_comb begin
    rd_nxt = '0;
    if (bus_addr == ADDR_W'(LOCK_ADDR))
      rd_nxt = DATA_W'(lock_q);
    for (int c = 0; c < NUM_CH; c++) begin
      case (sel[c])
        SEL_CTRL: rd_nxt = DATA_W'(ctrl_q[c]);
        SEL_STAT: rd_nxt = DATA_W'(stat_q[c]);
        SEL_CNT:  rd_nxt = DATA_W'(cnt_q[c]);
        SEL_PTR:  rd_nxt = ptr_q[c];
        SEL_FIN:  rd_nxt = DATA_W'(fin_q[c]);
        SEL_FOUT: rd_nxt = DATA_W'(fout_q[c]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_nxt;
    end
  end
endmodule

// File: rtl/dmactl_regs_sva.sv
module dmactl_regs_sva #(
  parameter int NUM_CH     = 2,
  parameter int UNLOCK_VAL = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_rvalid,
  input logic [NUM_CH-1:0] go_pulse,
  input logic [NUM_CH-1:0] eng_rst,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] reg_mode,
  input logic [7:0]        lock_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    p_go_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go_pulse[c] |=> !go_pulse[c]);
    p_go_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      go_pulse[c] |-> ($past(lock_q) == 8'(UNLOCK_VAL)));
    p_go_not_in_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      go_pulse[c] |-> !eng_rst[c]);
    p_rst_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rst[c] |-> !irq[c]);
    p_go_leaves_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
      go_pulse[c] |-> !reg_mode[c]);
  end

  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  p_no_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

bind dmactl_regs dmactl_regs_sva #(
  .NUM_CH(NUM_CH), .UNLOCK_VAL(UNLOCK_VAL)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_rvalid(bus_rvalid),
  .go_pulse  (go_pulse),
  .eng_rst   (eng_rst),
  .irq       (irq),
  .reg_mode  (reg_mode),
  .lock_q    (lock_q)
);

// File: tb/sim_dmactl_regs.sv
`timescale 1ns/1ps
module sim_dmactl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  evt_done = '0, evt_uirq = '0, evt_perr = '0;
  logic [1:0]  go_pulse, eng_rst, irq, reg_mode;
  logic [31:0] cpb_count;
  logic [63:0] next_cpb;
  logic [31:0] fifo_in_thr, fifo_out_thr;

  int n_chk = 0, n_fail = 0;
  int go0 = 0, go1 = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dmactl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .evt_done(evt_done), .evt_uirq(evt_uirq),
    .evt_perr(evt_perr), .go_pulse(go_pulse), .eng_rst(eng_rst), .irq(irq),
    .reg_mode(reg_mode), .cpb_count(cpb_count), .next_cpb(next_cpb),
    .fifo_in_thr(fifo_in_thr), .fifo_out_thr(fifo_out_thr)
  );

  always @(negedge clk) begin
    if (go_pulse[0]) go0++;
    if (go_pulse[1]) go1++;
  end

  // {addr, write data, expected readback}
  localparam logic [71:0] VEC [9] = '{
    {8'hC7, 32'h0000_0107, 32'h0000_0007},
    {8'h84, 32'h0001_ABCD, 32'h0000_ABCD},
    {8'hA4, 32'h0000_0001, 32'h0000_0001},
    {8'h8C, 32'h1234_5678, 32'h1234_5678},
    {8'hAC, 32'hCAFE_F00D, 32'hCAFE_F00D},
    {8'h94, 32'hFFFF_0100, 32'h0000_0100},
    {8'hB6, 32'h0000_0080, 32'h0000_0080},
    {8'h60, 32'h0000_0055, 32'h0000_0000},
    {8'hA0, 32'h0000_0002, 32'h0000_0002}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    #1;
    chk(bus_rvalid === 1'b1, "R10 rvalid", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [1:0] dn, input logic [1:0] ui,
                       input logic [1:0] pe);
    @(negedge clk);
    evt_done = dn; evt_uirq = ui; evt_perr = pe;
    @(negedge clk);
    evt_done = '0; evt_uirq = '0; evt_perr = '0;
    #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    logic [31:0] d;
    int g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2 reset state
    chk(go_pulse == 2'b00 && eng_rst == 2'b00 && irq == 2'b00, "R2 outputs",
        32'({go_pulse, eng_rst, irq}), 32'd0);
    chk(reg_mode == 2'b11, "R2 reg_mode", 32'(reg_mode), 32'd3);
    rd(8'h80, d); chk(d == 32'h0, "R2 ctrl0", d, 32'h0);
    rd(8'hA2, d); chk(d == 32'h0, "R2 stat1", d, 32'h0);
    rd(8'hC7, d); chk(d == 32'h0, "R2 lock", d, 32'h0);

    // R4 start while locked
    g = go0;
    wr(8'h80, 32'h0083);
    repeat (3) @(negedge clk);
    chk(go0 == g, "R4 no go when locked", 32'(go0 - g), 32'd0);
    chk(reg_mode[0] == 1'b1, "R4 reg_mode", 32'(reg_mode[0]), 32'd1);

    // R1 vector walk
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], d);
      chk(d == VEC[i][31:0], "R1 readback", d, VEC[i][31:0]);
    end
    chk(next_cpb[63:32] == 32'hCAFEF00D, "R1 next_cpb port", next_cpb[63:32],
        32'hCAFEF00D);
    chk(cpb_count[15:0] == 16'hABCD, "R1 cpb_count port", 32'(cpb_count[15:0]),
        32'hABCD);

    // R3 start pulse, R6 reg_mode
    g = go0;
    wr(8'h80, 32'h0083);
    chk(go_pulse == 2'b01, "R3 pulse cycle", 32'(go_pulse), 32'd1);
    chk(reg_mode[0] == 1'b0, "R6 reg_mode low", 32'(reg_mode[0]), 32'd0);
    @(negedge clk); #1;
    chk(go_pulse == 2'b00, "R3 one cycle", 32'(go_pulse), 32'd0);
    chk(go0 == g + 1 && go1 == 0, "R3 count", 32'(go0 - g), 32'd1);
    rd(8'h80, d); chk(d == 32'h0003, "R3 go reads 0", d, 32'h0003);
    wr(8'h80, 32'h0003);
    chk(reg_mode[0] == 1'b1, "R6 reg_mode high", 32'(reg_mode[0]), 32'd1);

    // R7/R9/R8/R11 events
    pulse(2'b01, 2'b00, 2'b00);
    chk(irq == 2'b01, "R9 irq ch0", 32'(irq), 32'd1);
    rd(8'h82, d); chk(d == 32'h40, "R7 done bit6", d, 32'h40);
    chk(irq == 2'b00, "R8 irq cleared", 32'(irq), 32'd0);
    rd(8'h82, d); chk(d == 32'h0, "R8 cleared", d, 32'h0);
    pulse(2'b00, 2'b10, 2'b10);
    chk(irq == 2'b10, "R11 irq ch1 only", 32'(irq), 32'd2);
    rd(8'h82, d); chk(d == 32'h0, "R11 ch0 untouched", d, 32'h0);
    rd(8'hA2, d); chk(d == 32'h11, "R7 uirq+perr", d, 32'h11);

    // R8 event during the read cycle
    pulse(2'b00, 2'b00, 2'b01);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'h82; evt_done = 2'b01;
    @(negedge clk);
    bus_rd = 1'b0; evt_done = '0;
    #1;
    chk(bus_rdata == 32'h01, "R8 old value", bus_rdata, 32'h01);
    rd(8'h82, d); chk(d == 32'h40, "R8 new event kept", d, 32'h40);

    // R9 mask
    wr(8'h80, 32'h0103);
    pulse(2'b00, 2'b00, 2'b01);
    chk(irq[0] == 1'b0, "R9 masked", 32'(irq[0]), 32'd0);
    wr(8'h80, 32'h0003);
    chk(irq[0] == 1'b1, "R9 unmasked", 32'(irq[0]), 32'd1);

    // R5 reset bit
    wr(8'h80, 32'h0023);
    chk(eng_rst == 2'b01, "R5 eng_rst", 32'(eng_rst), 32'd1);
    chk(irq[0] == 1'b0, "R5 status cleared irq", 32'(irq[0]), 32'd0);
    pulse(2'b01, 2'b01, 2'b01);
    rd(8'h82, d); chk(d == 32'h0, "R5 events dropped", d, 32'h0);
    g = go0;
    wr(8'h80, 32'h00A3);
    repeat (2) @(negedge clk);
    chk(go0 == g, "R5 go suppressed", 32'(go0 - g), 32'd0);
    wr(8'h80, 32'h0003);
    chk(eng_rst == 2'b00, "R5 released", 32'(eng_rst), 32'd0);

    // R4 lock changed away from unlock value
    wr(8'hC7, 32'h06);
    g = go1;
    wr(8'hA0, 32'h0082);
    repeat (2) @(negedge clk);
    chk(go1 == g && reg_mode[1] == 1'b1, "R4 relocked", 32'(go1 - g), 32'd0);

    summary();
  end
endmodule